// File: doc/BRIEF.md
# Six-Step Commutation PWM Controller

This block drives the six switches of a three-phase bridge for block-commutated motor control. A free-running up-counter sets a fixed PWM frame. Each phase compares the count against its own constant to form a PWM reference. Every phase has a high-side output and a low-side output, and each of these is gated by its own enable bit.

The six enable bits are double-buffered. A shadow copy always holds the pattern for the upcoming step, and the live copy gates the outputs. A commutation event copies the whole shadow into the live copy at one clock edge, so every output switches in the same cycle. At that same edge the sequencer advances and reloads the shadow with the pattern that follows. An event comes from a one-cycle software strobe or from a rising edge on an asynchronous trigger input, and every event raises an interrupt flag. Typical use is a periodic strobe from a system tick, or a hall-sensor edge on the trigger input.

Top module: `six_step_pwm`

## Requirements
- R1: The counter starts at 0 after reset, adds one each clock, and returns to 0 after reaching PERIOD (default 4095). A PWM frame is therefore PERIOD+1 clocks.
- R2: The reference of a phase is active while the count is below that phase's compare value (defaults: phase 1 2047, phase 2 1023, phase 3 511). An enabled output is high for exactly that many clocks in each frame.
- R3: After reset all six outputs and the interrupt flag are low, and the shadow holds the step 1 pattern. The outputs stay low until the first event.
- R4: Successive events apply steps in this order. Step 1: phase 1 high side and phase 2 low side. Step 2: phase 3 high and phase 2 low. Step 3: phase 3 high and phase 1 low. Step 4: phase 2 high and phase 1 low. Step 5: phase 2 high and phase 3 low. Step 6: phase 1 high and phase 3 low. Output bit p of high_o and of low_o belongs to phase p+1.
- R5: In every step the four outputs not named for that step stay low. The high and low outputs of one phase are never high together.
- R6: Each clock cycle in which com_sw_i is high is one commutation event.
- R7: A rising edge on com_trig_i, after a two-stage synchronizer, causes one event. Holding the input high causes no further events.
- R8: All six enables change together, and only at the clock edge that registers an event.
- R9: After step 6, the next event applies step 1.
- R10: A strobe and a trigger edge in the same cycle count as a single event and advance one step.
- R11: Each event sets com_irq_o. A cycle with irq_clr_i high and no event clears it. If an event and a clear arrive in the same cycle, the flag is set.
- R12: The shadow is reloaded at the same edge as the transfer, so events in two consecutive cycles advance two steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| com_sw_i | input | 1 | Software commutation strobe, one event per high cycle |
| com_trig_i | input | 1 | Asynchronous trigger; a rising edge is an event |
| irq_clr_i | input | 1 | Clears the commutation interrupt flag |
| high_o | output | 3 | High-side gate outputs, bit p is phase p+1 |
| low_o | output | 3 | Low-side gate outputs, bit p is phase p+1 |
| com_irq_o | output | 1 | Commutation interrupt pending flag |

## Verification
A fault in the live enables appears at the ports within one PWM frame, either as a wrong set of toggling outputs or as a shoot-through pair. To catch it, the bench counts the high cycles of every output across a whole frame after each event. A fault in the sequencer index or the shadow stays hidden until the next event, and then shows as a wrong or repeated step. For this reason every step and the wrap back to step 1 are applied in turn. A counter or compare fault shows as a wrong high-cycle count over one frame. A fault in the synchronizer shows as a missing event, a doubled event, or an event that repeats while the trigger is held high.

// File: rtl/six_step_pkg.sv
package six_step_pkg;
  localparam int NUM_PH    = 3;
  localparam int NUM_OUT   = 2 * NUM_PH;
  localparam int NUM_STEPS = 6;

  typedef logic [2:0]         step_t;
  typedef logic [NUM_OUT-1:0] en_t;   // [2:0] high sides, [5:3] low sides

  function automatic en_t step_pattern(input step_t s);
    case (s)
      3'd0:    return 6'b010_001;
      3'd1:    return 6'b010_100;
      3'd2:    return 6'b001_100;
      3'd3:    return 6'b001_010;
      3'd4:    return 6'b100_010;
      3'd5:    return 6'b100_001;
      default: return '0;
    endcase
  endfunction

  function automatic step_t step_after(input step_t s);
    return (s == step_t'(NUM_STEPS - 1)) ? '0 : s + 3'd1;
  endfunction
endpackage

// File: rtl/ss_time_base.sv
module ss_time_base #(
  parameter int                      CNT_W   = 12,
  parameter int                      NUM_PH  = 3,
  parameter logic [CNT_W-1:0]        PERIOD  = '1,
  parameter logic [NUM_PH*CNT_W-1:0] CMP_VEC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [NUM_PH-1:0] ref_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == PERIOD) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_cmp
    assign ref_o[p] = cnt_q < CMP_VEC[p*CNT_W +: CNT_W];
  end

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == PERIOD |=> cnt_q == '0);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != PERIOD |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/ss_com_detect.sv
module ss_com_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_i,
  input  logic trig_i,
  output logic com_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 trig_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], trig_i};
  end

  assign trig_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign com_o     = sw_i | trig_rise;  // coincident sources merge into one event

  a_r7_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_rise |=> !trig_rise);
endmodule

// File: rtl/ss_step_seq.sv
module ss_step_seq
  import six_step_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic com_i,
  input  logic irq_clr_i,
  output en_t  en_o,
  output logic irq_o
);
  step_t step_q;    // step whose pattern sits in the shadow
  en_t   shadow_q;
  en_t   active_q;
  step_t step_nx;

  assign step_nx = step_after(step_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      shadow_q <= step_pattern('0);
      active_q <= '0;
    end else if (com_i) begin
      active_q <= shadow_q;
      step_q   <= step_nx;
      shadow_q <= step_pattern(step_nx);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_o <= 1'b0;
    else if (com_i)     irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end

  assign en_o = active_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_i |=> $stable(active_q));
  a_r12_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_i |=> active_q == $past(shadow_q));
  a_r5_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q == '0 || $countones(active_q) == 2);
  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_i && step_q == step_t'(NUM_STEPS - 1) |=> step_q == '0);
  a_r11_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_i |=> irq_o);
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_i && irq_clr_i |=> !irq_o);
endmodule

// File: rtl/six_step_pwm.sv
module six_step_pwm
  import six_step_pkg::*;
#(
  parameter int               CNT_W   = 12,
  parameter logic [CNT_W-1:0] PERIOD  = 12'd4095,
  parameter logic [CNT_W-1:0] CMP_PH1 = 12'd2047,
  parameter logic [CNT_W-1:0] CMP_PH2 = 12'd1023,
  parameter logic [CNT_W-1:0] CMP_PH3 = 12'd511
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              com_sw_i,
  input  logic              com_trig_i,
  input  logic              irq_clr_i,
  output logic [NUM_PH-1:0] high_o,
  output logic [NUM_PH-1:0] low_o,
  output logic              com_irq_o
);
  localparam logic [NUM_PH*CNT_W-1:0] CMP_VEC = {CMP_PH3, CMP_PH2, CMP_PH1};

  logic [NUM_PH-1:0] ref_w;
  logic              com_w;
  en_t               en_w;

  ss_time_base #(
    .CNT_W  (CNT_W),
    .NUM_PH (NUM_PH),
    .PERIOD (PERIOD),
    .CMP_VEC(CMP_VEC)
  ) u_time_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_o (ref_w)
  );

  ss_com_detect #(.SYNC_STAGES(2)) u_com_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sw_i  (com_sw_i),
    .trig_i(com_trig_i),
    .com_o (com_w)
  );

  ss_step_seq u_step_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .com_i    (com_w),
    .irq_clr_i(irq_clr_i),
    .en_o     (en_w),
    .irq_o    (com_irq_o)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    assign high_o[p] = en_w[p]          & ref_w[p];
    assign low_o[p]  = en_w[p + NUM_PH] & ref_w[p];

    a_r5_no_shoot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(high_o[p] && low_o[p]));
  end
endmodule

// File: tb/six_step_pwm_tb.sv
module six_step_pwm_tb;
  localparam int FRAME = 4096;
  localparam int WATCHDOG_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       com_sw = 1'b0;
  logic       com_trig = 1'b0;
  logic       irq_clr = 1'b0;
  logic [2:0] high, low;
  logic       com_irq;

  int checks = 0;
  int errors = 0;
  int cmp_val[3] = '{2047, 1023, 511};

  always #2 clk = ~clk;

  six_step_pwm u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .com_sw_i  (com_sw),
    .com_trig_i(com_trig),
    .irq_clr_i (irq_clr),
    .high_o    (high),
    .low_o     (low),
    .com_irq_o (com_irq)
  );

  // expected enables for step n (1..6), 0 = all off: {low[2:0], high[2:0]}
  function automatic logic [5:0] exp_en(input int n);
    logic [5:0] e = '0;
    case (n)
      1: begin e[0] = 1; e[4] = 1; end
      2: begin e[2] = 1; e[4] = 1; end
      3: begin e[2] = 1; e[3] = 1; end
      4: begin e[1] = 1; e[3] = 1; end
      5: begin e[1] = 1; e[5] = 1; end
      6: begin e[0] = 1; e[5] = 1; end
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // count high cycles of each output over a full frame
  task automatic check_frame(input string tag, input int step_n);
    int cnt[6] = '{default: 0};
    logic [5:0] e = exp_en(step_n);
    bit bad = 0;
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        cnt[k]   += int'(high[k]);
        cnt[k+3] += int'(low[k]);
      end
    end
    checks++;
    for (int k = 0; k < 6; k++) begin
      int want = e[k] ? cmp_val[k % 3] : 0;
      if (cnt[k] != want) begin
        bad = 1;
        $display("FAIL %s step %0d output %0d: got %0d high cycles expected %0d",
                 tag, step_n, k, cnt[k], want);
      end
    end
    if (bad) errors++;
  endtask

  task automatic sw_pulse(input int cycles);
    @(negedge clk) com_sw = 1'b1;
    repeat (cycles) @(negedge clk);
    com_sw = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    check_bit("R3 high_o zero", |high, 1'b0);
    check_bit("R3 low_o zero", |low, 1'b0);
    check_bit("R3 irq low", com_irq, 1'b0);
    check_frame("R3 R1 idle until first event", 0);
  endtask

  task automatic t_sw_sequence();
    sw_pulse(1);
    check_bit("R11 irq set by event", com_irq, 1'b1);
    check_frame("R6 R4 R2 step 1", 1);
    clear_irq();
    check_bit("R11 irq cleared", com_irq, 1'b0);
    for (int s = 2; s <= 6; s++) begin
      sw_pulse(1);
      check_frame("R4 R5 R8 sequence", s);
    end
    sw_pulse(1);
    check_frame("R9 wrap to step 1", 1);
  endtask

  task automatic t_trigger();
    clear_irq();
    @(negedge clk) com_trig = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R7 irq from trigger edge", com_irq, 1'b1);
    clear_irq();
    check_frame("R7 trigger edge gives step 2, level held", 2);
    check_bit("R7 held level raises no event", com_irq, 1'b0);
    @(negedge clk) com_trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_coincident();
    @(negedge clk) com_trig = 1'b1;
    @(negedge clk);
    @(negedge clk) com_sw = 1'b1;   // same cycle as synchronized edge
    @(negedge clk) com_sw = 1'b0;
    check_frame("R10 strobe and edge count once", 3);
    @(negedge clk) com_trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    sw_pulse(2);
    check_frame("R12 consecutive events advance two steps", 5);
  endtask

  task automatic t_irq_priority();
    clear_irq();
    @(negedge clk) begin com_sw = 1'b1; irq_clr = 1'b1; end
    @(negedge clk) begin com_sw = 1'b0; irq_clr = 1'b0; end
    check_bit("R11 event wins over clear", com_irq, 1'b1);
    check_frame("R4 step 6 after priority event", 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_sw_sequence();
    t_trigger();
    t_coincident();
    t_back_to_back();
    t_irq_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule